// File: doc/BRIEF.md
# FIFO Threshold DMA Request Controller

This block sits beside the receive and transmit FIFOs of a network controller. It decides when the DMA engine must ask for the bus, and when the current burst is over. It watches the occupancy count of each FIFO and compares it with a threshold. Each threshold is picked by a 2-bit encoded field, and the receive and transmit sides use different tables. A receive burst is wanted once enough words have collected. A transmit burst is wanted once the FIFO has drained below its threshold.

A single block-mode input picks one of two ways to end a burst. In empty/fill mode, a receive burst runs until the FIFO is empty and a transmit burst runs until the FIFO is full. In block mode, a burst moves a fixed number of words taken from the threshold. A transmit burst in block mode is cut short to the free space in the FIFO. The DMA engine reports each moved word on a strobe, and the block answers with a one-cycle burst-end pulse on the last word. Receive wins when both sides want the bus at once.

Top module: `dma_req_ctrl`

## Requirements
- R1: The receive threshold select maps 0, 1, 2 and 3 to 2, 4, 8 and 12 words. Any value above DEPTH is clamped to DEPTH. When the controller is idle and rx_level is at or above this threshold, rx_req is high from the next cycle.
- R2: The transmit threshold select maps 0, 1, 2 and 3 to 4, 8, 12 and 14 words, again clamped to DEPTH. When the controller is idle, no receive request is due, and tx_level is below this threshold, tx_req is high from the next cycle.
- R3: When both conditions hold in the same idle cycle, the receive burst is granted. rx_req and tx_req are never high together.
- R4: In empty/fill mode (block_mode 0 at burst start), a receive burst ends with burst_end high in the cycle where word_xfer is high and rx_level is 1 or 0.
- R5: In empty/fill mode, a transmit burst ends with burst_end high in the cycle where word_xfer is high and tx_level is at least DEPTH-1.
- R6: In block mode (block_mode 1 at burst start), a receive burst ends with burst_end high on the word_xfer strobe that carries the threshold-th word.
- R7: In block mode, a transmit burst moves the smaller of the transmit threshold and DEPTH minus tx_level, both sampled in the start cycle. burst_end is high on the strobe that carries that last word.
- R8: burst_end is high only during a burst, and only together with word_xfer. Strobes outside a burst are ignored. Both requests are low for the two cycles that follow burst_end.
- R9: While rst_n is low, and in the first cycle after reset, rx_req, tx_req and burst_end are low. The threshold and mode are sampled at burst start, so changing them mid-burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | CNT_W | Words held in the receive FIFO (0..DEPTH) |
| tx_level | input | CNT_W | Words held in the transmit FIFO (0..DEPTH) |
| rx_thr_sel | input | 2 | Receive threshold select |
| tx_thr_sel | input | 2 | Transmit threshold select |
| block_mode | input | 1 | 1: fixed-count bursts, 0: empty/fill bursts |
| word_xfer | input | 1 | One word moved by the DMA engine this cycle |
| rx_req | output | 1 | Receive burst request |
| tx_req | output | 1 | Transmit burst request |
| burst_end | output | 1 | High on the last word of the current burst |

## Verification
The bench builds the block with DEPTH set to 10, not the default of 16. With that depth, the receive selects 0 to 2 and the transmit selects 0 to 1 use their table values directly. The receive select 3 and the transmit selects 2 and 3 are clamped, so both paths of the decode are tested in one build. A depth of 10 also lets random occupancy values reach both the full and the empty boundary often. That exercises the transmit cap on free space and both empty/fill exits within a short run.

// File: rtl/dma_req_pkg.sv
// Shared types for the FIFO threshold DMA request controller.
package dma_req_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RX   = 2'd1,
        ST_TX   = 2'd2,
        ST_GAP  = 2'd3
    } dma_state_t;
endpackage

// File: rtl/dma_thr_decode.sv
// Turns a 2-bit threshold select into a word count, clamped to DEPTH.
// IS_TX picks the transmit table (4/8/12/14) or the receive table
// (2/4/8/12). The block is purely combinational.
module dma_thr_decode #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5,
    parameter bit IS_TX = 1'b0
) (
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] thr
);
    int raw;

    generate
        if (IS_TX) begin : g_tx
            // Transmit table lookup.
            always_comb begin
                case (sel)
                    2'd0:    raw = 4;
                    2'd1:    raw = 8;
                    2'd2:    raw = 12;
                    default: raw = 14;
                endcase
            end
        end else begin : g_rx
            // Receive table lookup.
            always_comb begin
                case (sel)
                    2'd0:    raw = 2;
                    2'd1:    raw = 4;
                    2'd2:    raw = 8;
                    default: raw = 12;
                endcase
            end
        end
    endgenerate

    // Clamp the table value to the FIFO depth.
    always_comb begin
        thr = (raw > DEPTH) ? CNT_W'(DEPTH) : CNT_W'(raw);
    end
endmodule

// File: rtl/dma_burst_tracker.sv
// Tracks one burst. It samples the length, the mode and the direction
// at start, counts strobes, and flags the last word. It assumes start
// is only pulsed while active is low, and that the FIFO levels stay
// within 0..DEPTH.
module dma_burst_tracker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] start_len,
    input  logic             start_blk,
    input  logic             start_is_tx,
    input  logic             active,
    input  logic             word_xfer,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] tx_level,
    output logic             last
);
    localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] cnt_q;
    logic             blk_q;
    logic             is_tx_q;
    logic             cond_done;

    // Sample the burst settings at start and count the words moved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q   <= '0;
            cnt_q   <= '0;
            blk_q   <= 1'b0;
            is_tx_q <= 1'b0;
        end else if (start) begin
            len_q   <= start_len;
            cnt_q   <= '0;
            blk_q   <= start_blk;
            is_tx_q <= start_is_tx;
        end else if (active && word_xfer) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // Decide whether the word on the bus this cycle ends the burst.
    always_comb begin
        if (blk_q)
            cond_done = (cnt_q == (len_q - ONE));
        else if (is_tx_q)
            cond_done = (tx_level >= FULL_M1);
        else
            cond_done = (rx_level <= ONE);
        last = active && word_xfer && cond_done;
    end

    // R6 R7: a block-mode burst never counts past its sampled length.
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && blk_q) |-> (cnt_q < len_q));
endmodule

// File: rtl/dma_req_ctrl.sv
// Bus request arbiter for the receive and transmit FIFOs. From idle, it
// grants a receive burst when rx_level reaches its threshold, or else a
// transmit burst when tx_level is below its threshold. It holds the
// request until the tracker flags the last word. It then spends one gap
// cycle and one idle cycle before it evaluates the requests again.
// It assumes both levels stay within 0..DEPTH.
module dma_req_ctrl #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] tx_level,
    input  logic [1:0]       rx_thr_sel,
    input  logic [1:0]       tx_thr_sel,
    input  logic             block_mode,
    input  logic             word_xfer,
    output logic             rx_req,
    output logic             tx_req,
    output logic             burst_end
);
    import dma_req_pkg::*;

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    dma_state_t       state_q, state_d;
    logic [CNT_W-1:0] rx_thr, tx_thr, tx_space, tx_len;
    logic             rx_hit, tx_hit, start, last, active;
    logic [CNT_W-1:0] start_len;

    dma_thr_decode #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_TX(1'b0)) u_rx_thr (
        .sel(rx_thr_sel), .thr(rx_thr));
    dma_thr_decode #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_TX(1'b1)) u_tx_thr (
        .sel(tx_thr_sel), .thr(tx_thr));

    // Compare the levels with the thresholds and work out the capped
    // transmit block length.
    always_comb begin
        rx_hit   = (rx_level >= rx_thr);
        tx_hit   = (tx_level < tx_thr);
        tx_space = DEPTH_C - tx_level;
        tx_len   = (tx_space < tx_thr) ? tx_space : tx_thr;
    end

    // Choose the next state, with receive first when both are due.
    always_comb begin
        state_d   = state_q;
        start     = 1'b0;
        start_len = rx_thr;
        case (state_q)
            ST_IDLE: begin
                if (rx_hit) begin
                    state_d   = ST_RX;
                    start     = 1'b1;
                    start_len = rx_thr;
                end else if (tx_hit) begin
                    state_d   = ST_TX;
                    start     = 1'b1;
                    start_len = tx_len;
                end
            end
            ST_RX, ST_TX: if (last) state_d = ST_GAP;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign active    = (state_q == ST_RX) || (state_q == ST_TX);
    assign rx_req    = (state_q == ST_RX);
    assign tx_req    = (state_q == ST_TX);
    assign burst_end = last;

    dma_burst_tracker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_track (
        .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
        .start_blk(block_mode), .start_is_tx(state_d == ST_TX),
        .active(active), .word_xfer(word_xfer),
        .rx_level(rx_level), .tx_level(tx_level), .last(last));

    // R3: the two requests are mutually exclusive.
    assert_one_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_req && tx_req));
    // R1: a receive request only rises after the level met the threshold.
    assert_rx_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_req) |-> ($past(rx_level) >= $past(rx_thr)));
    // R2: a transmit request only rises after the level was below threshold.
    assert_tx_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_req) |-> ($past(tx_level) < $past(tx_thr)));
    // R8: burst end only inside a burst with a strobe.
    assert_end_in_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end |-> ((rx_req || tx_req) && word_xfer));
    // R8: both requests are low in the cycle after burst end.
    assert_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end |=> (!rx_req && !tx_req));
endmodule

// File: tb/tb_dma_req_ctrl.sv
// Self-checking bench. A reference model built from the requirements
// runs in step with the design, under directed and random stimulus.
module tb_dma_req_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 10;
    localparam int CNT_W      = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CNT_W-1:0] rx_level = '0, tx_level = '0;
    logic [1:0] rx_thr_sel = '0, tx_thr_sel = '0;
    logic block_mode = 1'b0, word_xfer = 1'b0;
    logic rx_req, tx_req, burst_end;

    int errors = 0, checks = 0, cycles = 0;
    int ms = 0, mlen = 0, mcnt = 0;
    bit mblk = 1'b0;

    dma_req_ctrl #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
        .rx_thr_sel(rx_thr_sel), .tx_thr_sel(tx_thr_sel),
        .block_mode(block_mode), .word_xfer(word_xfer),
        .rx_req(rx_req), .tx_req(tx_req), .burst_end(burst_end));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycles++;

    function automatic int rx_thr_f(input int s);
        int t;
        t = (s == 0) ? 2 : (s == 1) ? 4 : (s == 2) ? 8 : 12;
        return (t > DEPTH) ? DEPTH : t;
    endfunction

    function automatic int tx_thr_f(input int s);
        int t;
        t = (s == 0) ? 4 : (s == 1) ? 8 : (s == 2) ? 12 : 14;
        return (t > DEPTH) ? DEPTH : t;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle at the falling edge, compare with the model, then
    // advance the model across the next rising edge.
    task automatic step(input int rl, input int tl, input int rs, input int ts,
                        input bit bm, input bit wx);
        bit rhit, thit, e_rx, e_tx, e_end;
        string rtag, etag;
        rx_level = CNT_W'(rl); tx_level = CNT_W'(tl);
        rx_thr_sel = 2'(rs); tx_thr_sel = 2'(ts);
        block_mode = bm; word_xfer = wx;
        #1;
        rhit  = (rl >= rx_thr_f(rs));
        thit  = (tl < tx_thr_f(ts));
        e_rx  = (ms == 1);
        e_tx  = (ms == 2);
        e_end = (ms == 1 || ms == 2) && wx &&
                (mblk ? (mcnt == mlen - 1) : (ms == 2) ? (tl >= DEPTH - 1) : (rl <= 1));
        rtag  = (ms == 3) ? "R8 req low after end" :
                (ms == 1) ? "R1 rx_req" : (ms == 2) ? "R2 tx_req" : "R3 idle reqs";
        etag  = (ms == 0 || ms == 3) ? "R8 burst_end outside burst" :
                mblk ? ((ms == 1) ? "R6 rx block end" : "R7 tx block end") :
                       ((ms == 1) ? "R4 rx empty end" : "R5 tx fill end");
        check(rx_req == e_rx, rtag, rx_req, e_rx);
        check(tx_req == e_tx, rtag, tx_req, e_tx);
        check(burst_end == e_end, etag, burst_end, e_end);
        case (ms)
            0: if (rhit) begin
                   ms = 1; mlen = rx_thr_f(rs); mblk = bm; mcnt = 0;
               end else if (thit) begin
                   ms = 2; mblk = bm; mcnt = 0;
                   mlen = (DEPTH - tl < tx_thr_f(ts)) ? DEPTH - tl : tx_thr_f(ts);
               end
            1, 2: if (e_end) ms = 3; else if (wx) mcnt++;
            default: ms = 0;
        endcase
        @(posedge clk);
        @(negedge clk);
    endtask

    // Bring the model and the design back to idle.
    task automatic settle();
        for (int i = 0; i < 40 && ms != 0; i++) step(0, DEPTH, 0, 0, 0, 1);
        step(0, DEPTH, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd1234);
        @(negedge clk);
        word_xfer = 1'b1; rx_level = CNT_W'(DEPTH);
        repeat (3) begin
            @(negedge clk);
            check(!rx_req && !tx_req && !burst_end, "R9 outputs low in reset",
                  {rx_req, tx_req, burst_end}, 0);
        end
        rst_n = 1'b1;
        step(0, DEPTH, 0, 0, 0, 0);

        // R1 clamp: receive select 3 means 10 words at DEPTH 10.
        step(9, DEPTH, 3, 0, 0, 0);
        step(9, DEPTH, 3, 0, 0, 0);
        check(rx_req == 0, "R1 level 9 below clamped 10", rx_req, 0);
        step(10, DEPTH, 3, 0, 0, 0);
        check(rx_req == 1, "R1 level 10 meets clamped 10", rx_req, 1);
        step(5, DEPTH, 3, 0, 0, 1);
        check(burst_end == 0, "R4 not yet empty", burst_end, 0);
        step(1, DEPTH, 3, 0, 1, 1);
        step(0, DEPTH, 0, 0, 0, 0);
        check(rx_req == 0, "R8 req low after end", rx_req, 0);
        settle();

        // R2 clamp and R7 cap: select 3 means 10 words, level 7 leaves 3 free.
        step(0, 9, 0, 3, 1, 0);
        check(tx_req == 1, "R2 level 9 below clamped 10", tx_req, 1);
        settle();
        step(0, 7, 0, 3, 1, 0);
        step(0, 0, 2, 0, 0, 1);
        step(0, 0, 2, 0, 0, 1);
        check(tx_req == 1 && burst_end == 1, "R7 capped burst ends on third word",
              burst_end, 1);
        step(0, 0, 2, 0, 0, 1);
        settle();

        // R3: both due, receive wins.
        step(4, 0, 0, 0, 1, 0);
        check(rx_req == 1 && tx_req == 0, "R3 receive priority", tx_req, 0);
        // R9: a config change mid-burst keeps the sampled length of 2.
        step(0, 0, 3, 3, 0, 1);
        check(burst_end == 1, "R9 sampled length kept", burst_end, 1);
        step(0, DEPTH, 0, 0, 0, 0);
        settle();

        // R8: strobes while idle are ignored.
        step(0, DEPTH, 0, 0, 1, 1);
        check(burst_end == 0 && rx_req == 0, "R8 idle strobe ignored", burst_end, 0);

        // Random phase.
        for (int n = 0; n < 4000; n++) begin
            int rl, tl, rs, ts;
            rl = int'($urandom % (DEPTH + 1));
            tl = int'($urandom % (DEPTH + 1));
            rs = int'($urandom % 4);
            ts = int'($urandom % 4);
            step(rl, tl, rs, ts, 1'($urandom % 2), 1'($urandom % 2));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule